// File: doc/BRIEF.md
# Page Write-Lock Filter

This block stands between a command decoder and the write port of a byte-wide nonvolatile array that holds one user zone. Each write request brings a zone protection mode, a start address, a byte count and up to eight data bytes. The filter reads the current contents back from the array, decides byte by byte what may be stored, and drives the array write port. When the request is finished it raises a one-cycle completion pulse, together with an error flag if any byte was refused.

There are four protection modes. Open mode stores the bytes as given. Program-only mode can clear stored bits but never set them. Forbidden mode refuses everything. Page-lock mode splits the zone into 8-byte pages. The byte at the lowest address of each page is an access mask for the whole page, and bit n of that mask guards the byte at page offset n. In page-lock mode a request stores at most one byte, and the mask byte itself only ever loses ones.

The controller is a state machine with five states. `ST_IDLE` waits for a request. `ST_MASK_RD` reads the page's access byte (page-lock mode only). `ST_OLD_RD` reads the byte about to be written and, in page-lock mode, captures the mask. `ST_WRITE` writes the filtered byte or refuses it. `ST_DONE` pulses completion.

The transitions are:
- IDLE to DONE, on a forbidden-mode request or a request with a count of zero.
- IDLE to MASK_RD, on a page-lock request.
- IDLE to OLD_RD, on any other request.
- MASK_RD to OLD_RD.
- OLD_RD to WRITE.
- WRITE to OLD_RD, while open or program-only bytes remain.
- WRITE to DONE, on the last byte or after any page-lock byte.
- DONE to IDLE.

Top module: `page_wlock_filter`

## Requirements
- R1: After reset, `busy`, `arr_we`, `done` and `err` are all 0.
- R2: In open mode (`req_mode` = 2'b00), a request with count n stores lane i of `req_data` (bits 8i+7..8i) at address (`req_addr` + i) modulo 64, for i from 0 to n-1. A count above 8 is treated as 8. Each address is written once, and `err` stays 0.
- R3: In program-only mode (`req_mode` = 2'b01), each byte is stored as the AND of its old value and the new lane, so no stored bit goes from 0 to 1. The addressing is the same as in R2, and `err` stays 0.
- R4: In forbidden mode (`req_mode` = 2'b11), no byte is written, whatever the count, and `err` is 1 with `done`.
- R5: In page-lock mode (`req_mode` = 2'b10), a request with a nonzero count writes at most one byte, at `req_addr`, from lane 0. The other lanes are ignored.
- R6: In page-lock mode, the access byte of a target address is the byte at that address with its low three bits cleared. For a target at page offset o from 1 to 7, lane 0 is stored unchanged if bit o of the access byte is 1. If that bit is 0, nothing is written and `err` is 1 with `done`.
- R7: In page-lock mode, a write to page offset 0 stores the AND of the old access byte and lane 0 if bit 0 of the access byte is 1. If bit 0 is 0, nothing is written and `err` is 1 with `done`.
- R8: In open, program-only and page-lock modes, a request with a count of zero writes nothing and completes with `err` = 0.
- R9: A `req_valid` pulse while `busy` is 1 is ignored. It causes no write and no extra `done`.
- R10: `done` is a single-cycle pulse, given exactly once per accepted request, and `err` is 1 only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_mode | input | 2 | Zone protection mode |
| req_addr | input | 6 | Start byte address within the zone |
| req_cnt | input | 4 | Number of bytes requested |
| req_data | input | 64 | Data lanes; lane i is bits 8i+7..8i |
| busy | output | 1 | A request is in progress |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rd_addr | output | 6 | Array read address |
| arr_rd_data | input | 8 | Array read data, valid one cycle after the strobe |
| arr_we | output | 1 | Array write strobe |
| arr_wr_addr | output | 6 | Array write address |
| arr_wr_data | output | 8 | Array write data |
| done | output | 1 | Request complete (one cycle) |
| err | output | 1 | Some byte of the request was refused |

## Verification
The bench keeps its own copy of the array and sweeps page-lock writes over every page offset under several mask patterns, covering masks that are all ones, all zeros and mixed. Getting the bit-to-offset mapping wrong would store bytes that the mask guards. Not ANDing the access byte would let a cleared lock bit come back to 1. The bench also checks that bytes past the first are dropped in page-lock mode; a design that got this wrong would write the following bytes across the page. Other cases target program-only data that tries to raise bits, a count of zero and a count above eight, address wrap at the end of the zone, and a request that arrives while busy, which a careless controller would accept and apply.

// File: rtl/wlf_pkg.sv
package wlf_pkg;

    typedef enum logic [1:0] {
        MODE_OPEN   = 2'b00,
        MODE_PROG   = 2'b01,
        MODE_WLOCK  = 2'b10,
        MODE_FORBID = 2'b11
    } zone_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_MASK_RD = 3'd1,
        ST_OLD_RD  = 3'd2,
        ST_WRITE   = 3'd3,
        ST_DONE    = 3'd4
    } wlf_state_e;

endpackage

// File: rtl/wlf_req_regs.sv
module wlf_req_regs
    import wlf_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int MAX_BURST = 8,
    parameter int CNT_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          advance,
    input  logic [ADDR_W-1:0]             in_addr,
    input  logic [CNT_W-1:0]              in_cnt,
    input  logic [MAX_BURST*DATA_W-1:0]   in_data,
    input  zone_mode_e                    in_mode,
    output logic [ADDR_W-1:0]             cur_addr,
    output logic [DATA_W-1:0]             cur_byte,
    output logic                          last,
    output zone_mode_e                    mode_q
);
    localparam int BUS_W = MAX_BURST * DATA_W;
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_BURST);

    logic [BUS_W-1:0] data_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            data_q   <= '0;
            left_q   <= '0;
            mode_q   <= MODE_OPEN;
        end else if (load) begin
            cur_addr <= in_addr;
            data_q   <= in_data;
            left_q   <= (in_cnt > CNT_CAP) ? CNT_CAP : in_cnt;
            mode_q   <= in_mode;
        end else if (advance) begin
            cur_addr <= cur_addr + 1'b1;
            left_q   <= left_q - 1'b1;
            data_q   <= {{DATA_W{1'b0}}, data_q[BUS_W-1:DATA_W]};
        end
    end

    assign cur_byte = data_q[DATA_W-1:0];
    assign last     = (left_q == CNT_W'(1));

endmodule

// File: rtl/wlf_merge.sv
module wlf_merge
    import wlf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 3
) (
    input  zone_mode_e        mode,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] old_b,
    input  logic [DATA_W-1:0] new_b,
    output logic              allow,
    output logic [DATA_W-1:0] merged
);
    always_comb begin
        allow  = 1'b0;
        merged = new_b;
        unique case (mode)
            MODE_OPEN: begin
                allow  = 1'b1;
                merged = new_b;
            end
            MODE_PROG: begin
                allow  = 1'b1;
                merged = old_b & new_b;
            end
            MODE_WLOCK: begin
                allow  = mask[ofs];
                merged = (ofs == '0) ? (old_b & new_b) : new_b;
            end
            MODE_FORBID: begin
                allow  = 1'b0;
                merged = old_b;
            end
            default: begin
                allow  = 1'b0;
                merged = old_b;
            end
        endcase
    end

endmodule

// File: rtl/wlf_ctrl.sv
module wlf_ctrl
    import wlf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  zone_mode_e req_mode,
    input  logic       req_cnt_zero,
    input  zone_mode_e mode_q,
    input  logic       last,
    input  logic       allow,
    output logic       busy,
    output logic       load,
    output logic       advance,
    output logic       rd_en,
    output logic       rd_mask,
    output logic       mask_cap,
    output logic       we,
    output logic       done,
    output logic       err
);
    wlf_state_e state_q, state_d;
    logic       err_q;
    logic       err_set;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_mode == MODE_FORBID || req_cnt_zero) state_d = ST_DONE;
                    else if (req_mode == MODE_WLOCK)             state_d = ST_MASK_RD;
                    else                                         state_d = ST_OLD_RD;
                end
            end
            ST_MASK_RD: state_d = ST_OLD_RD;
            ST_OLD_RD:  state_d = ST_WRITE;
            ST_WRITE:   state_d = (last || mode_q == MODE_WLOCK) ? ST_DONE : ST_OLD_RD;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load     = 1'b0;
        advance  = 1'b0;
        rd_en    = 1'b0;
        rd_mask  = 1'b0;
        mask_cap = 1'b0;
        we       = 1'b0;
        done     = 1'b0;
        err_set  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load    = req_valid;
                err_set = req_valid && (req_mode == MODE_FORBID);
            end
            ST_MASK_RD: begin
                rd_en   = 1'b1;
                rd_mask = 1'b1;
            end
            ST_OLD_RD: begin
                rd_en    = 1'b1;
                mask_cap = (mode_q == MODE_WLOCK);
            end
            ST_WRITE: begin
                we      = allow;
                err_set = !allow;
                advance = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if (load)    err_q <= 1'b0;
    end

    assign busy = (state_q != ST_IDLE);
    assign err  = done && err_q;

endmodule

// File: rtl/page_wlock_filter.sv
module page_wlock_filter
    import wlf_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int MAX_BURST = 8,
    parameter int CNT_W     = $clog2(MAX_BURST + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_mode,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [CNT_W-1:0]            req_cnt,
    input  logic [MAX_BURST*DATA_W-1:0] req_data,
    output logic                        busy,
    output logic                        arr_rd_en,
    output logic [ADDR_W-1:0]           arr_rd_addr,
    input  logic [DATA_W-1:0]           arr_rd_data,
    output logic                        arr_we,
    output logic [ADDR_W-1:0]           arr_wr_addr,
    output logic [DATA_W-1:0]           arr_wr_data,
    output logic                        done,
    output logic                        err
);
    // one mask bit per byte of a page
    localparam int PAGE_BYTES = DATA_W;
    localparam int OFS_W      = $clog2(PAGE_BYTES);

    zone_mode_e        mode_in, mode_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_byte, mask_q, merged;
    logic              last, allow, load, advance, rd_mask, mask_cap;

    assign mode_in = zone_mode_e'(req_mode);

    wlf_req_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST), .CNT_W(CNT_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .in_addr(req_addr), .in_cnt(req_cnt), .in_data(req_data), .in_mode(mode_in),
        .cur_addr(cur_addr), .cur_byte(cur_byte), .last(last), .mode_q(mode_q)
    );

    wlf_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(mode_in),
        .req_cnt_zero(req_cnt == '0), .mode_q(mode_q), .last(last), .allow(allow),
        .busy(busy), .load(load), .advance(advance), .rd_en(arr_rd_en),
        .rd_mask(rd_mask), .mask_cap(mask_cap), .we(arr_we), .done(done), .err(err)
    );

    wlf_merge #(.DATA_W(DATA_W), .OFS_W(OFS_W)) merge_i (
        .mode(mode_q), .ofs(cur_addr[OFS_W-1:0]), .mask(mask_q),
        .old_b(arr_rd_data), .new_b(cur_byte), .allow(allow), .merged(merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (mask_cap) mask_q <= arr_rd_data;
    end

    assign arr_rd_addr = rd_mask ? {cur_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}} : cur_addr;
    assign arr_wr_addr = cur_addr;
    assign arr_wr_data = merged;

endmodule

// File: rtl/wlf_checker.sv
module wlf_checker #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int MAX_BURST = 8,
    parameter int CNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_mode,
    input logic              busy,
    input logic              arr_rd_en,
    input logic [ADDR_W-1:0] arr_rd_addr,
    input logic [DATA_W-1:0] arr_rd_data,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_wr_addr,
    input logic [DATA_W-1:0] arr_wr_data,
    input logic              done,
    input logic              err
);
    logic [1:0] cap_mode;
    logic [7:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_mode <= 2'b00;
            wr_cnt   <= '0;
        end else if (req_valid && !busy) begin
            cap_mode <= req_mode;
            wr_cnt   <= '0;
        end else if (arr_we) begin
            wr_cnt   <= wr_cnt + 1'b1;
        end
    end

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ($past(arr_rd_en) && arr_wr_addr == $past(arr_rd_addr))); // R2
    AST_PROG_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && cap_mode == 2'b01) |-> ((arr_wr_data & ~arr_rd_data) == '0)); // R3
    AST_FORBID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cap_mode == 2'b11) |-> !arr_we); // R4
    AST_WLOCK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && cap_mode == 2'b10) |-> (wr_cnt == '0)); // R5
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arr_we); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R10

endmodule

bind page_wlock_filter wlf_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode), .busy(busy),
    .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
    .arr_we(arr_we), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
    .done(done), .err(err)
);

// File: tb/page_wlock_filter_tb_top.sv
module page_wlock_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [5:0]  req_addr = '0;
    logic [3:0]  req_cnt = '0;
    logic [63:0] req_data = '0;
    logic        busy, arr_rd_en, arr_we, done, err;
    logic [5:0]  arr_rd_addr, arr_wr_addr;
    logic [7:0]  arr_rd_data, arr_wr_data;

    logic [7:0] mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    int checks = 0, failures = 0, cycles = 0;
    int wr_seen = 0, done_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_wlock_filter dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_addr(req_addr), .req_cnt(req_cnt), .req_data(req_data), .busy(busy),
        .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
        .arr_we(arr_we), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .done(done), .err(err)
    );

    // array model, one-cycle read latency
    always @(posedge clk) begin
        if (arr_we) mem[arr_wr_addr] <= arr_wr_data;
        if (arr_rd_en) arr_rd_data <= mem[arr_rd_addr];
        if (arr_we) wr_seen <= wr_seen + 1;
        if (done) done_seen <= done_seen + 1;
        cycles <= cycles + 1;
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] m, input int a, input int n, input logic [63:0] d,
                           input string rq, input bit inject);
        int exp_wr = 0;
        bit exp_err = 0;
        int eff_n = (n > 8) ? 8 : n;
        int bad = -1;
        bit saw_err;
        int guard = 0;
        // expected outcome from the requirements
        if (m == 2'b11) exp_err = 1;
        else if (m == 2'b10) begin
            if (eff_n > 0) begin
                int base = a & ~7;
                int o = a & 7;
                if (exp_mem[base][o]) begin
                    exp_wr = 1;
                    exp_mem[a] = (o == 0) ? (exp_mem[a] & d[7:0]) : d[7:0];
                end else exp_err = 1;
            end
        end else begin
            for (int i = 0; i < eff_n; i++) begin
                int ad = (a + i) % DEPTH;
                exp_mem[ad] = (m == 2'b01) ? (exp_mem[ad] & d[8*i +: 8]) : d[8*i +: 8];
            end
            exp_wr = eff_n;
        end
        wr_seen = 0; done_seen = 0;
        @(negedge clk);
        req_valid = 1; req_mode = m; req_addr = 6'(a); req_cnt = 4'(n); req_data = d;
        @(negedge clk);
        req_valid = 0;
        while (!done && guard < 40) begin
            @(negedge clk);
            guard++;
            if (inject && guard == 1) begin
                req_valid = 1; req_mode = 2'b00; req_addr = 6'(a ^ 32);
                req_cnt = 4'd3; req_data = ~d;
            end
            if (inject && guard == 2) req_valid = 0;
        end
        check(done === 1'b1, rq, "done seen", done, 1);
        saw_err = err;
        @(negedge clk);
        check(done === 1'b0, "R10", "done pulse width", done, 0);
        check(saw_err == exp_err, rq, "err", saw_err, exp_err);
        check(wr_seen == exp_wr, rq, "write count", wr_seen, exp_wr);
        check(done_seen == 1, "R10", "done count", done_seen, 1);
        for (int i = 0; i < DEPTH; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        if (bad >= 0) check(0, rq, $sformatf("mem[%0d]", bad), mem[bad], exp_mem[bad]);
        else check(1, rq, "mem", 0, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        check(busy == 0 && arr_we == 0 && done == 0 && err == 0, "R1", "reset outputs",
              {busy, arr_we, done, err}, 0);
        rst_n = 1;
        // R2: fill the zone in bursts of eight
        for (int p = 0; p < 8; p++) begin
            logic [63:0] d;
            for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'((p*8 + i) * 37 + 5);
            run_req(2'b00, p*8, 8, d, "R2", 0);
        end
        for (int n = 1; n <= 8; n++) run_req(2'b00, 3*n, n, 64'h0123_4567_89AB_CDEF ^ 64'(n), "R2", 0);
        run_req(2'b00, 60, 8, 64'hA1B2_C3D4_E5F6_0718, "R2", 0);   // wrap
        run_req(2'b00, 20, 12, 64'h1122_3344_5566_7788, "R2", 0);  // capped count
        // R3: program-only cannot raise bits
        run_req(2'b00, 40, 4, 64'h0000_0000_0F0F_3355, "R3", 0);
        run_req(2'b01, 40, 4, 64'h0000_0000_FFFF_FFFF, "R3", 0);
        run_req(2'b01, 39, 6, 64'h0000_5A5A_A5A5_F00F, "R3", 0);
        // R8: zero count
        run_req(2'b00, 5, 0, 64'hFFFF, "R8", 0);
        run_req(2'b01, 5, 0, 64'h0, "R8", 0);
        run_req(2'b10, 17, 0, 64'h0, "R8", 0);
        // R4: forbidden
        run_req(2'b11, 8, 1, 64'hFF, "R4", 0);
        run_req(2'b11, 9, 3, 64'h00_0000, "R4", 0);
        run_req(2'b11, 10, 0, 64'h0, "R4", 0);
        // R5/R6/R7: page lock over masks and offsets
        begin
            logic [7:0] masks [6] = '{8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hFE, 8'h01};
            for (int k = 0; k < 6; k++) begin
                run_req(2'b00, 16, 1, 64'(masks[k]), "R2", 0);
                for (int o = 1; o < 8; o++)
                    run_req(2'b10, 16 + o, 3, 64'h00_C3_E7 ^ 64'(o * 17 + k), "R6", 0);
                run_req(2'b10, 16, 2, 64'h77_3C, "R7", 0);
                run_req(2'b10, 16, 1, 64'hFF, "R7", 0);
                run_req(2'b10, 23, 4, 64'h99_88_77_66, "R5", 0);
            end
        end
        // R9: request while busy
        run_req(2'b00, 2, 6, 64'h0000_1357_9BDF_2468, "R9", 1);
        run_req(2'b01, 50, 5, 64'h0000_00F0_E0D0_C0B0, "R9", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule